// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the current time and date as seven byte registers: seconds, minutes, hours, day of month, weekday, month and year. Every field except the weekday is stored as BCD. A single-cycle one-second pulse on `tick` advances the time. A carry then runs through the fields and takes account of month lengths and leap years. The hours field can count in a 24-hour BCD form or in a 12-hour form with an AM/PM bit. The `mode_12h` input selects which form is used. The stored value is not converted when the mode changes.

A host reaches the registers through a byte-wide port addressed by register index. The read data depends only on the address and has no delay. A write takes effect at the clock edge. Counting is held while the host holds `bus_active`, and also in any cycle with `wr_en` set. A host can therefore read several registers as one consistent snapshot, or write them, without a carry landing halfway through. One tick that arrives during the hold is remembered and applied as soon as the hold ends. Bit 7 of the seconds register is a flag that records a possible loss of time. The `stop` input halts counting completely.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows: seconds 80h (flag set, value 00), minutes 00h, hours 00h, day 01h, weekday 00h, month 01h, year 00h.
- R2: Seconds and minutes count BCD 00 to 59. On each advance the seconds step by one. Seconds 59 wraps to 00 and steps the minutes. Minutes 59 wraps to 00 and steps the hours.
- R3: With `mode_12h`=0 the hours register (bits 5:0) counts BCD 00 to 23. Hour 23 wraps to 00 and steps the day.
- R4: With `mode_12h`=1, bit 5 of the hours register is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 01 and keeps PM. The day steps only on 11 PM to 12 AM.
- R5: A day step wraps the day to 01 and steps the month once the day has reached the month length. The lengths are 31 days, 30 days for months 04, 06, 09 and 11, and for month 02 29 days if the BCD year is a multiple of 4 (00 included) and 28 otherwise. Month 12 wraps to 01 and steps the year, and year 99 wraps to 00. The weekday (0 to 6) steps with every day step, and 6 wraps to 0.
- R6: While `bus_active` or `wr_en` is 1, no register advances. If one or more ticks arrive during the hold, the registers advance exactly once, at the clock edge of the first cycle with both inputs low.
- R7: While `stop` is 1, no register advances and ticks are discarded. A tick held from an earlier access is also dropped.
- R8: Seconds bit 7 is 1 after reset. A write to the seconds register with bit 7 = 0 clears it. Nothing else sets or clears it.
- R9: A write to the seconds register discards any held tick, so the next advance waits for a new tick.
- R10: Bits that are not implemented read 0, and writes to them are ignored. Implemented bits: minutes 6:0, hours 5:0, day 5:0, weekday 2:0, month 4:0. Any address outside 03h to 09h reads 00h.
- R11: The addresses are seconds 03h, minutes 04h, hours 05h, day 06h, weekday 07h, month 08h, year 09h. `rdata` follows `addr` in the same cycle, and a write is visible after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| mode_12h | input | 1 | 1 selects the 12-hour hours format |
| stop | input | 1 | 1 halts counting |
| bus_active | input | 1 | Host access window; counting is held while set |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The read data depends only on the address and the stored state, so the bench samples a register in the same cycle as the address. Writes and tick advances appear after the rising edge that samples them. A tick held during an access is applied on the rising edge of the first cycle with `bus_active` and `wr_en` both low. The bench model updates on that same rising edge. Every register is then compared at the falling edge that follows, with the address swept in sub-nanosecond steps well before the next rising edge. Targeted checks with fixed expected bytes are placed in that same window, after the cycle in which each rollover, hold release or write is due.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_12h,
  input  logic              stop,
  input  logic              bus_active,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MIN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DAY = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_WD  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_YR  = ADDR_W'(9);

  logic       osf_q, pend_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, day_q;
  logic [2:0] wday_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  wire hold  = bus_active | wr_en;
  wire step  = !stop && !hold && (tick || pend_q);

  wire [7:0] sec_inc = bcd_inc({1'b0, sec_q});
  wire [7:0] min_inc = bcd_inc({1'b0, min_q});
  wire [7:0] h24_inc = bcd_inc({2'b0, hr_q});
  wire [7:0] h12_inc = bcd_inc({3'b0, hr_q[4:0]});
  wire [7:0] day_inc = bcd_inc({2'b0, day_q});
  wire [7:0] mon_inc = bcd_inc({3'b0, mon_q});
  wire [7:0] yr_inc  = bcd_inc(yr_q);

  wire h_is11  = hr_q[4:0] == 5'h11;
  wire h_is12  = hr_q[4:0] == 5'h12;
  wire sec_end = sec_q == 7'h59;
  wire min_end = min_q == 7'h59;
  wire hr_end  = mode_12h ? (h_is11 && hr_q[5]) : (hr_q == 6'h23);

  wire leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                      : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);

  logic [5:0] month_len;
  always_comb begin
    case (mon_q)
      5'h02:                      month_len = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_len = 6'h30;
      default:                    month_len = 6'h31;
    endcase
  end

  logic [5:0] hr_nx;
  always_comb begin
    if (mode_12h) begin
      if (h_is11)      hr_nx = {~hr_q[5], 5'h12};
      else if (h_is12) hr_nx = {hr_q[5], 5'h01};
      else             hr_nx = {hr_q[5], h12_inc[4:0]};
    end else begin
      hr_nx = hr_end ? 6'h00 : h24_inc[5:0];
    end
  end

  wire c_min = step && sec_end;
  wire c_hr  = c_min && min_end;
  wire c_day = c_hr && hr_end;
  wire c_mon = c_day && (day_q >= month_len);
  wire c_yr  = c_mon && (mon_q == 5'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osf_q  <= 1'b1;
      pend_q <= 1'b0;
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      day_q  <= 6'h01;
      wday_q <= '0;
      mon_q  <= 5'h01;
      yr_q   <= '0;
    end else begin
      if (stop || (wr_en && addr == A_SEC)) pend_q <= 1'b0;
      else if (hold)                        pend_q <= pend_q | tick;
      else                                  pend_q <= 1'b0;

      if (wr_en) begin
        case (addr)
          A_SEC: begin sec_q <= wdata[6:0]; osf_q <= osf_q & wdata[7]; end
          A_MIN: min_q  <= wdata[6:0];
          A_HR:  hr_q   <= wdata[5:0];
          A_DAY: day_q  <= wdata[5:0];
          A_WD:  wday_q <= wdata[2:0];
          A_MON: mon_q  <= wdata[4:0];
          A_YR:  yr_q   <= wdata;
          default: ;
        endcase
      end else begin
        if (step)  sec_q <= sec_end ? 7'h00 : sec_inc[6:0];
        if (c_min) min_q <= min_end ? 7'h00 : min_inc[6:0];
        if (c_hr)  hr_q  <= hr_nx;
        if (c_day) begin
          day_q  <= (day_q >= month_len) ? 6'h01 : day_inc[5:0];
          wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
        end
        if (c_mon) mon_q <= (mon_q == 5'h12) ? 5'h01 : mon_inc[4:0];
        if (c_yr)  yr_q  <= (yr_q == 8'h99) ? 8'h00 : yr_inc;
      end
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = {osf_q, sec_q};
      A_MIN:   rdata = {1'b0, min_q};
      A_HR:    rdata = {2'b0, hr_q};
      A_DAY:   rdata = {2'b0, day_q};
      A_WD:    rdata = {5'b0, wday_q};
      A_MON:   rdata = {3'b0, mon_q};
      A_YR:    rdata = yr_q;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              stop,
  input logic              bus_active,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              osf_q,
  input logic [6:0]        sec_q,
  input logic [6:0]        min_q,
  input logic [5:0]        hr_q,
  input logic [5:0]        day_q,
  input logic [2:0]        wday_q,
  input logic [4:0]        mon_q,
  input logic [7:0]        yr_q
);
  wire [43:0] time_vec = {sec_q, min_q, hr_q, day_q, wday_q, mon_q, yr_q, 2'b00};

  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !wr_en) |=> $stable(time_vec));

  a_r7_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(time_vec));

  a_r8_flag_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(osf_q));

  a_r2_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_active && !wr_en && !stop && tick && sec_q == 7'h59) |=> (sec_q == 7'h00));

  a_r5_weekday_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wday_q <= 3'd6 && !wr_en) |=> (wday_q <= 3'd6));

  a_r9_sec_write_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) ##1 (!bus_active && !wr_en && !tick) |=> $stable(sec_q));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .bus_active(bus_active),
  .wr_en(wr_en), .addr(addr), .osf_q(osf_q), .sec_q(sec_q), .min_q(min_q),
  .hr_q(hr_q), .day_q(day_q), .wday_q(wday_q), .mon_q(mon_q), .yr_q(yr_q)
);

// File: tb/rtc_calendar_core_tb_top.sv
`timescale 1ns/10ps
module rtc_calendar_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mode_12h = 1'b0, stop = 1'b0, bus_active = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_tag = "R1";

  logic [7:0] mreg [3:9];
  bit mpend;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_12h(mode_12h), .stop(stop),
    .bus_active(bus_active), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic model_reset();
    mreg[3] = 8'h80; mreg[4] = 8'h00; mreg[5] = 8'h00; mreg[6] = 8'h01;
    mreg[7] = 8'h00; mreg[8] = 8'h01; mreg[9] = 8'h00; mpend = 0;
  endtask

  task automatic model_advance();
    int s, m, h, d, mo, y, lim;
    bit pm, carry;
    s = b2i({1'b0, mreg[3][6:0]}) + 1;
    if (s < 60) begin mreg[3] = {mreg[3][7], i2b(s)[6:0]}; return; end
    mreg[3] = {mreg[3][7], 7'h00};
    m = b2i(mreg[4]) + 1;
    if (m < 60) begin mreg[4] = i2b(m); return; end
    mreg[4] = 8'h00;
    carry = 0;
    if (mode_12h) begin
      logic [7:0] t;
      h = b2i({3'b0, mreg[5][4:0]});
      pm = mreg[5][5];
      if (h == 11) begin h = 12; carry = pm; pm = !pm; end
      else if (h == 12) h = 1;
      else h = h + 1;
      t = i2b(h);
      mreg[5] = {2'b00, pm, t[4:0]};
    end else begin
      h = b2i(mreg[5]) + 1;
      if (h == 24) begin h = 0; carry = 1; end
      mreg[5] = i2b(h);
    end
    if (!carry) return;
    d = b2i(mreg[6]); mo = b2i(mreg[8]); y = b2i(mreg[9]);
    case (mo)
      2: lim = (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: lim = 30;
      default: lim = 31;
    endcase
    mreg[7] = 8'((int'(mreg[7]) + 1) % 7);
    if (d >= lim) begin
      d = 1; mo = mo + 1;
      if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
    end else d = d + 1;
    mreg[6] = i2b(d); mreg[8] = i2b(mo); mreg[9] = i2b(y);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit adv, hold;
      hold = bus_active || wr_en;
      adv = !stop && !hold && (tick || mpend);
      if (wr_en) begin
        case (addr)
          8'h03: mreg[3] = {mreg[3][7] & wdata[7], wdata[6:0]};
          8'h04: mreg[4] = {1'b0, wdata[6:0]};
          8'h05: mreg[5] = {2'b0, wdata[5:0]};
          8'h06: mreg[6] = {2'b0, wdata[5:0]};
          8'h07: mreg[7] = {5'b0, wdata[2:0]};
          8'h08: mreg[8] = {3'b0, wdata[4:0]};
          8'h09: mreg[9] = wdata;
          default: ;
        endcase
      end else if (adv) model_advance();
      if (stop || (wr_en && addr == 8'h03)) mpend = 0;
      else if (hold) mpend = mpend | tick;
      else mpend = 0;
    end
  end

  task automatic check_byte(logic [7:0] a, logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr %02h actual %02h expected %02h", tag, a, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] keep;
    keep = addr;
    for (int a = 3; a <= 9; a++) begin
      addr = 8'(a);
      #0.2;
      check_byte(addr, rdata, mreg[a], cur_tag);
    end
    addr = keep;
  endtask

  task automatic expect_reg(logic [7:0] a, logic [7:0] exp, string tag);
    logic [7:0] keep;
    keep = addr;
    addr = a;
    #0.2;
    check_byte(a, rdata, exp, tag);
    addr = keep;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(bit t, bit ba, bit we, logic [7:0] a, logic [7:0] d);
    tick = t; bus_active = ba; wr_en = we; addr = a; wdata = d;
    cycle();
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    drive(0, 1, 1, a, d);
  endtask

  task automatic idle(); drive(0, 0, 0, 8'h00, 8'h00); endtask
  task automatic tick_once(); drive(1, 0, 0, 8'h00, 8'h00); endtask

  task automatic set_time(logic [7:0] yr, logic [7:0] mo, logic [7:0] dy, logic [7:0] wd,
                          logic [7:0] hr, logic [7:0] mi, logic [7:0] se);
    write_reg(8'h09, yr); write_reg(8'h08, mo); write_reg(8'h06, dy);
    write_reg(8'h07, wd); write_reg(8'h05, hr); write_reg(8'h04, mi);
    write_reg(8'h03, se);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.1;
    cur_tag = "R1";
    expect_reg(8'h03, 8'h80, "R1"); expect_reg(8'h04, 8'h00, "R1");
    expect_reg(8'h05, 8'h00, "R1"); expect_reg(8'h06, 8'h01, "R1");
    expect_reg(8'h07, 8'h00, "R1"); expect_reg(8'h08, 8'h01, "R1");
    expect_reg(8'h09, 8'h00, "R1");
    idle();

    cur_tag = "R10";
    write_reg(8'h04, 8'hFF); expect_reg(8'h04, 8'h7F, "R10");
    write_reg(8'h05, 8'hFF); expect_reg(8'h05, 8'h3F, "R10");
    write_reg(8'h06, 8'hFF); expect_reg(8'h06, 8'h3F, "R10");
    write_reg(8'h07, 8'hFF); expect_reg(8'h07, 8'h07, "R10");
    write_reg(8'h08, 8'hFF); expect_reg(8'h08, 8'h1F, "R10");
    write_reg(8'h0A, 8'h55); expect_reg(8'h0A, 8'h00, "R10");
    expect_reg(8'h02, 8'h00, "R10");
    cur_tag = "R11";
    write_reg(8'h09, 8'h47); expect_reg(8'h09, 8'h47, "R11");

    cur_tag = "R8";
    write_reg(8'h03, 8'h80); expect_reg(8'h03, 8'h80, "R8");
    write_reg(8'h03, 8'h05); expect_reg(8'h03, 8'h05, "R8");
    write_reg(8'h03, 8'h80); expect_reg(8'h03, 8'h00, "R8");
    idle();

    cur_tag = "R3";
    mode_12h = 0;
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h03, 8'h00, "R2"); expect_reg(8'h04, 8'h00, "R2");
    expect_reg(8'h05, 8'h00, "R3"); expect_reg(8'h06, 8'h01, "R5");
    expect_reg(8'h07, 8'h00, "R5"); expect_reg(8'h08, 8'h01, "R5");
    expect_reg(8'h09, 8'h00, "R5");

    cur_tag = "R5";
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h06, 8'h01, "R5"); expect_reg(8'h08, 8'h03, "R5");
    set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h06, 8'h29, "R5"); expect_reg(8'h08, 8'h02, "R5");
    set_time(8'h00, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h06, 8'h01, "R5"); expect_reg(8'h08, 8'h03, "R5");
    set_time(8'h31, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h06, 8'h01, "R5"); expect_reg(8'h08, 8'h05, "R5");
    expect_reg(8'h07, 8'h06, "R5");

    cur_tag = "R4";
    mode_12h = 1;
    set_time(8'h10, 8'h01, 8'h05, 8'h03, 8'h31, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h05, 8'h12, "R4"); expect_reg(8'h06, 8'h06, "R4");
    set_time(8'h10, 8'h01, 8'h05, 8'h03, 8'h11, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h05, 8'h32, "R4"); expect_reg(8'h06, 8'h05, "R4");
    set_time(8'h10, 8'h01, 8'h05, 8'h03, 8'h32, 8'h59, 8'h59);
    tick_once();
    expect_reg(8'h05, 8'h21, "R4");

    cur_tag = "R6";
    mode_12h = 0;
    set_time(8'h10, 8'h01, 8'h05, 8'h03, 8'h08, 8'h00, 8'h10);
    drive(1, 1, 0, 8'h03, 8'h00);
    drive(1, 1, 0, 8'h03, 8'h00);
    drive(0, 1, 0, 8'h03, 8'h00);
    expect_reg(8'h03, 8'h10, "R6");
    idle();
    expect_reg(8'h03, 8'h11, "R6");
    idle();
    expect_reg(8'h03, 8'h11, "R6");
    drive(1, 1, 1, 8'h04, 8'h22);
    idle();
    expect_reg(8'h03, 8'h12, "R6"); expect_reg(8'h04, 8'h22, "R6");

    cur_tag = "R9";
    drive(1, 1, 0, 8'h03, 8'h00);
    drive(0, 1, 1, 8'h03, 8'h20);
    idle();
    expect_reg(8'h03, 8'h20, "R9");
    tick_once();
    expect_reg(8'h03, 8'h21, "R9");

    cur_tag = "R7";
    stop = 1;
    tick_once(); tick_once();
    expect_reg(8'h03, 8'h21, "R7");
    drive(1, 1, 0, 8'h03, 8'h00);
    stop = 0;
    idle();
    expect_reg(8'h03, 8'h21, "R7");
    stop = 1;
    drive(1, 1, 0, 8'h03, 8'h00);
    stop = 0;
    idle();
    expect_reg(8'h03, 8'h21, "R7");

    cur_tag = "R2";
    set_time(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h58, 8'h00);
    for (int i = 0; i < 150; i++) begin
      if (i % 3 == 2) idle();
      else tick_once();
    end
    expect_reg(8'h04, 8'h59, "R2");
    mode_12h = 1;
    cur_tag = "R4";
    set_time(8'h07, 8'h06, 8'h30, 8'h01, 8'h31, 8'h58, 8'h30);
    for (int i = 0; i < 200; i++) begin
      if (i % 50 == 7) drive(1, 1, 0, 8'h05, 8'h00);
      else tick_once();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule